// File: doc/BRIEF.md
# Per-Pad Drive Strength Selector

This block keeps the output drive strength chosen for each pad of a general-purpose I/O port. Software sees three 32-bit registers: one for low, one for medium and one for high drive. Each register has one bit per pad. The hardware keeps the three bits of a pad exclusive, so exactly one of them is set at any time. Setting a pad's bit in one register clears that pad's bits in the other two. Writing a 0 leaves the pad unchanged.

Software reaches the registers through a plain synchronous bus with an address, a write strobe, write data and read data. The bus has no handshake and no back-pressure: a write is taken on the rising edge on which the strobe is high, and read data follows the address in the same cycle. The block feeds each pad driver a 3-bit one-hot code. A short register pipeline separates that code from the register state, so a new setting reaches the pad in the cycle after it is stored.

Top module: `drive_select_bank`

## Requirements
- R1: After reset the low-drive register reads 0x000000FF and the medium-drive and high-drive registers read 0x00000000, so every pad starts in low drive.
- R2: The low-drive register is at address 0x500, medium-drive at 0x504 and high-drive at 0x508. Bit n of a register belongs to pad n, and a read returns the current contents in the same cycle as the address.
- R3: Writing 1 to bit n of the low-drive register sets that bit and clears bit n in the medium-drive and high-drive registers.
- R4: Writing 1 to bit n of the medium-drive or the high-drive register sets that bit and clears bit n in the other two registers.
- R5: A write changes only the pads whose data bit is 1. Writing 0 to a bit has no effect, and one write can move several pads at once.
- R6: Bits 31:8 of every drive register read as zero, and writes to them are ignored.
- R7: For every pad, exactly one of its three register bits is set at all times.
- R8: The pad output for pad n is `pad_drive[3n+2:3n]`, with bit 0 meaning low, bit 1 meaning medium and bit 2 meaning high drive. It changes on the first rising edge after the edge that captures the write, so the new setting is in effect from the second clock cycle after the write cycle.
- R9: Writes to any other address change nothing, and reads from any other address return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address within the port window |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| pad_drive | output | 24 | One-hot drive code per pad, three bits per pad |

## Verification
The bench uses the default build: eight pads, a 12-bit address and a settling delay of two cycles. With these values, every pad, every reserved bit and every address in the window can be driven with random writes. Random addresses fall mostly on the three registers and sometimes elsewhere, and the data is random, so multi-pad moves, zero bits and writes to unmapped addresses all occur. After each write, the bench checks the one-cycle output delay and the exclusivity of all three readbacks.

// File: rtl/drv_pkg.sv
package drv_pkg;
  localparam int unsigned NUM_LEVELS = 3;
  localparam int unsigned LVL_LOW  = 0;
  localparam int unsigned LVL_MED  = 1;
  localparam int unsigned LVL_HIGH = 2;
  localparam logic [NUM_LEVELS-1:0] LOW_ONEHOT = 3'b001;
endpackage

// File: rtl/drv_addr_decode.sv
module drv_addr_decode #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BASE     = 32'h500,
  parameter int unsigned STRIDE   = 4
) (
  input  logic [ADDR_W-1:0]             addr_i,
  output logic [drv_pkg::NUM_LEVELS-1:0] hit_o
);
  for (genvar l = 0; l < drv_pkg::NUM_LEVELS; l++) begin : g_hit
    localparam int unsigned OFS = BASE + l * STRIDE;
    assign hit_o[l] = (addr_i == ADDR_W'(OFS));
  end
endmodule

// File: rtl/drv_pad_cell.sv
module drv_pad_cell (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_any_i,
  input  logic [drv_pkg::NUM_LEVELS-1:0]  lvl_hit_i,
  input  logic                            set_i,
  output logic [drv_pkg::NUM_LEVELS-1:0]  state_o
);
  import drv_pkg::*;

  logic take;
  assign take = wr_any_i && set_i;

  always_ff @(posedge clk) begin
    if (!rst_n)    state_o <= LOW_ONEHOT;
    else if (take) state_o <= lvl_hit_i;
  end

  // R7
  state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_o) == 1);

  // R3
  low_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && lvl_hit_i[LVL_LOW]) |=> (state_o == 3'b001));

  // R4
  upper_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (lvl_hit_i[LVL_MED] || lvl_hit_i[LVL_HIGH])) |=> !state_o[LVL_LOW]);

  // R5
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(state_o));
endmodule

// File: rtl/drv_pipe.sv
module drv_pipe #(
  parameter int unsigned WIDTH  = 24,
  parameter int unsigned STAGES = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_regs
    logic [WIDTH-1:0] stg [STAGES];
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= (s == 0) ? d_i : stg[(s == 0) ? 0 : s-1];
      end
    end
    assign q_o = stg[STAGES-1];
  end
endmodule

// File: rtl/drive_select_bank.sv
module drive_select_bank #(
  parameter int unsigned NUM_PADS      = 8,
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned BASE_OFS      = 32'h500,
  parameter int unsigned REG_STRIDE    = 4,
  parameter int unsigned SETTLE_CYCLES = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [ADDR_W-1:0]                     bus_addr,
  input  logic                                  bus_we,
  input  logic [DATA_W-1:0]                     bus_wdata,
  output logic [DATA_W-1:0]                     bus_rdata,
  output logic [NUM_PADS*drv_pkg::NUM_LEVELS-1:0] pad_drive
);
  import drv_pkg::*;

  localparam int unsigned CODE_W     = NUM_PADS * NUM_LEVELS;
  localparam int unsigned PIPE_DEPTH = (SETTLE_CYCLES > 0) ? SETTLE_CYCLES - 1 : 0;
  localparam logic [CODE_W-1:0] RST_CODE = {NUM_PADS{LOW_ONEHOT}};

  logic [NUM_LEVELS-1:0] hit;
  logic                  wr_any;
  logic [NUM_PADS-1:0][NUM_LEVELS-1:0] pad_state;
  logic [NUM_PADS-1:0]   level_vec [NUM_LEVELS];

  drv_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE_OFS), .STRIDE(REG_STRIDE)) u_dec (
    .addr_i (bus_addr),
    .hit_o  (hit)
  );

  assign wr_any = bus_we && (|hit);

  for (genvar n = 0; n < NUM_PADS; n++) begin : g_pad
    drv_pad_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_any_i  (wr_any),
      .lvl_hit_i (hit),
      .set_i     (bus_wdata[n]),
      .state_o   (pad_state[n])
    );
    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
      assign level_vec[l][n] = pad_state[n][l];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (hit[l]) bus_rdata[NUM_PADS-1:0] = level_vec[l];
    end
  end

  drv_pipe #(.WIDTH(CODE_W), .STAGES(PIPE_DEPTH), .RST_VAL(RST_CODE)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pad_state),
    .q_o   (pad_drive)
  );

  for (genvar n = 0; n < NUM_PADS; n++) begin : g_out_chk
    // R8
    pad_out_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pad_drive[n*NUM_LEVELS +: NUM_LEVELS]) == 1);
  end

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !(|hit)) |=> $stable(pad_state));

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NUM_PADS] == '0);
endmodule

// File: tb/drive_select_bank_test.sv
`timescale 1ns/1ps
module drive_select_bank_test;
  localparam int NP = 8;
  localparam logic [11:0] A_LOW  = 12'h500;
  localparam logic [11:0] A_MED  = 12'h504;
  localparam logic [11:0] A_HIGH = 12'h508;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [23:0] pad_drive;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int mdl [NP];

  always #4 clk = ~clk;

  drive_select_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_drive(pad_drive)
  );

  function automatic logic [31:0] exp_reg(int lvl);
    logic [31:0] v = '0;
    for (int n = 0; n < NP; n++) if (mdl[n] == lvl) v[n] = 1'b1;
    return v;
  endfunction

  function automatic logic [23:0] exp_pads();
    logic [23:0] v = '0;
    for (int n = 0; n < NP; n++) v[3*n + mdl[n]] = 1'b1;
    return v;
  endfunction

  function automatic int lvl_of(logic [11:0] a);
    if (a == A_LOW)  return 0;
    if (a == A_MED)  return 1;
    if (a == A_HIGH) return 2;
    return -1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_all(string req);
    bus_addr = A_LOW;  #1; chk(req, bus_rdata, exp_reg(0));
    bus_addr = A_MED;  #1; chk(req, bus_rdata, exp_reg(1));
    bus_addr = A_HIGH; #1; chk(req, bus_rdata, exp_reg(2));
    for (int n = 0; n < NP; n++) begin
      bus_addr = A_LOW;  #1; checks++;
      begin
        logic [2:0] b;
        b[0] = bus_rdata[n];
        bus_addr = A_MED;  #1; b[1] = bus_rdata[n];
        bus_addr = A_HIGH; #1; b[2] = bus_rdata[n];
        if ($countones(b) != 1) begin
          failures++;
          $display("FAIL R7 pad %0d actual=%b expected=one-hot", n, b);
        end
      end
    end
  endtask

  task automatic do_write(logic [11:0] a, logic [31:0] d, string req);
    logic [23:0] old_pads;
    int lv;
    @(negedge clk);
    old_pads = exp_pads();
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
    lv = lvl_of(a);
    if (lv >= 0) for (int n = 0; n < NP; n++) if (d[n]) mdl[n] = lv;
    @(negedge clk);
    chk("R8 hold", {8'h0, pad_drive}, {8'h0, old_pads});
    @(negedge clk);
    chk("R8 new", {8'h0, pad_drive}, {8'h0, exp_pads()});
    read_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int n = 0; n < NP; n++) mdl[n] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    chk("R1 pads", {8'h0, pad_drive}, {8'h0, {8{3'b001}}});
    bus_addr = A_LOW;  #1; chk("R1 low", bus_rdata, 32'h000000FF);
    bus_addr = A_MED;  #1; chk("R1 med", bus_rdata, 32'h0);
    bus_addr = A_HIGH; #1; chk("R1 high", bus_rdata, 32'h0);
    // R9 unmapped read
    bus_addr = 12'h50C; #1; chk("R9 read", bus_rdata, 32'h0);
    do_write(A_MED,  32'h0000000F, "R4 med");
    do_write(A_HIGH, 32'h000000F0, "R4 high");
    do_write(A_LOW,  32'h00000000, "R5 zero");
    do_write(A_HIGH, 32'hFFFFFF00, "R6 reserved");
    bus_addr = A_HIGH; #1; chk("R6 high", bus_rdata, 32'h000000F0);
    do_write(12'h50C, 32'hFFFFFFFF, "R9 unmapped");
    do_write(12'h000, 32'hFFFFFFFF, "R9 zero addr");
    do_write(A_LOW,  32'h00000081, "R3 low");
    do_write(A_MED,  32'h00000024, "R2 med");
    do_write(A_LOW,  32'hFFFFFFFF, "R3 all");
    for (int i = 0; i < 300; i++) begin
      logic [11:0] a;
      int pick = $urandom % 8;
      if (pick < 2) a = A_LOW;
      else if (pick < 4) a = A_MED;
      else if (pick < 7) a = A_HIGH;
      else a = 12'($urandom);
      do_write(a, $urandom, "R5 random");
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule